// File: doc/BRIEF.md
# Masked Scalar Reciprocal Approximation Unit

This unit takes a single-precision floating-point operand and returns an estimate of its reciprocal whose relative error is guaranteed below 2^-14. The estimate packs into the low 32 bits of a 128-bit result. The upper 96 bits of that result are passed through from a first source operand. A one-bit write mask can replace the low lane. In merge mode the lane keeps the caller's previous destination word. In zeroing mode the lane is cleared. A mask-enable input can switch masking off entirely.

The estimate starts from a seed looked up by the leading mantissa bits. One fixed-point Newton-Raphson step then refines it. Zeros, infinities, NaNs, subnormal operands, results too tiny to be normal and results too large to represent all have dedicated handling. Two controls govern subnormal values:
- one forces subnormal inputs to zero;
- the other forces subnormal results to zero.

No rounding control is read and no exception flag is raised. The result and its valid flag are registered one cycle after the input valid.

Top module: `masked_rcp_unit`

## Requirements
- R1: For any finite normal operand whose reciprocal is normal, the low lane holds a value whose relative error against the true reciprocal is below 2^-14. For a subnormal result, the error is additionally allowed 2^-148 absolute.
- R2: Result bits 127:32 always equal `src1_hi_i`, whatever the mask controls.
- R3: When `mask_en_i` is 0, or `mask_i` is 1, the low lane is the reciprocal of `src2_lo_i`.
- R4: When `mask_en_i` is 1 and `mask_i` is 0, the low lane depends on `zero_mask_i`:
  - with `zero_mask_i` = 0 it is `dst_lo_i`;
  - with `zero_mask_i` = 1 it is 32'h0000_0000.
- R5: An operand of +0 gives 32'h7F80_0000, and an operand of -0 gives 32'hFF80_0000.
- R6: A subnormal operand (exponent field 0, fraction nonzero) depends on `daz_i`:
  - with `daz_i` = 1 it is treated as a zero of the same sign;
  - with `daz_i` = 0 it is normalised and its reciprocal computed.
- R7: When the reciprocal's biased exponent would be 0 or below, the result depends on `ftz_i`:
  - with `ftz_i` = 1 it is a zero of the operand's sign;
  - otherwise it is the subnormal encoding of the value.
- R8: A NaN operand (exponent field 255, fraction nonzero) is returned with fraction bit 22 set and every other bit unchanged. A quiet NaN is therefore returned unchanged.
- R9: An infinite operand gives a zero of the same sign.
- R10: A subnormal operand whose reciprocal exceeds the largest finite value gives an infinity of the same sign.
- R11: `valid_o` equals `valid_i` of the previous clock. The registered result updates only on cycles where `valid_i` is 1, and reset clears both.
- R12: An operand whose mantissa is exactly 1.0 gives an exact power-of-two reciprocal with a fraction field of 0, unless that result is subnormal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation request |
| src1_hi_i | input | 96 | Upper 96 bits of the first source, copied to result bits 127:32 |
| src2_lo_i | input | 32 | Single-precision operand to invert |
| dst_lo_i | input | 32 | Previous destination low word, kept under merge masking |
| mask_i | input | 1 | Write-mask bit for the low lane |
| mask_en_i | input | 1 | 1 applies the mask, 0 always writes the reciprocal |
| zero_mask_i | input | 1 | 1 selects zeroing, 0 selects merging when masked off |
| daz_i | input | 1 | Treat subnormal operands as zero |
| ftz_i | input | 1 | Force subnormal results to zero |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| res_o | output | 128 | Registered 128-bit result |

## Verification
The clocked checks assume that every input is a known value at each rising edge. They also assume that the mask and mode controls only matter on cycles where `valid_i` is high. The bench drives every input on the falling edge and holds it through the next rising edge. It lowers `valid_i` between operations, so each operation is captured exactly once. The combinational checks in the arithmetic core classify the operand only from its own bit fields, so they need no assumption about the operand's value range. The stimulus deliberately covers both extremes of the exponent range, so that the underflow and overflow paths are reached.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  typedef struct packed {
    logic        sign;
    logic [7:0]  exp;
    logic [22:0] frac;
  } fp32_t;

  localparam logic [7:0]  EXP_ALL1 = 8'hFF;
  localparam int unsigned FRAC_W   = 23;
  localparam logic [30:0] INF_MAG  = 31'h7F80_0000;
endpackage

// File: rtl/rcp_seed_rom.sv
module rcp_seed_rom #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned SEED_W = 16
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [SEED_W-1:0] seed_o
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [SEED_W-1:0] tbl [ENTRIES];

  // seed = 1 / midpoint of the mantissa interval, SEED_W fraction bits
  for (genvar i = 0; i < ENTRIES; i++) begin : g_seed
    localparam longint unsigned NUM = 64'd1 << (SEED_W + IDX_W + 1);
    localparam longint unsigned DEN = (64'd1 << (IDX_W + 1)) + 2 * i + 1;
    localparam longint unsigned VAL = NUM / DEN;
    assign tbl[i] = VAL[SEED_W-1:0];
  end

  assign seed_o = tbl[idx_i];
endmodule

// File: rtl/rcp_approx_core.sv
module rcp_approx_core
  import rcp_pkg::*;
#(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned SEED_W = 16
) (
  input  logic [31:0] op_i,
  input  logic        daz_i,
  input  logic        ftz_i,
  output logic [31:0] rcp_o
);
  localparam int unsigned P_W = FRAC_W + 1 + SEED_W;
  localparam int unsigned E_W = P_W + 1;
  localparam int unsigned Y_W = SEED_W + E_W;
  localparam int unsigned H   = FRAC_W - 1 + 2 * SEED_W;  // weight 0.5

  fp32_t op;
  assign op = op_i;

  logic is_nan, is_inf, is_sub, is_zero;
  assign is_nan  = (op.exp == EXP_ALL1) && (op.frac != '0);
  assign is_inf  = (op.exp == EXP_ALL1) && (op.frac == '0);
  assign is_sub  = (op.exp == '0) && (op.frac != '0);
  assign is_zero = (op.exp == '0) && ((op.frac == '0) || daz_i);

  // normalise subnormal operand
  logic [4:0]        lz;
  logic [23:0]       sh_frac;
  logic [22:0]       frac_n;
  logic signed [10:0] eb_eff;

  always_comb begin
    logic hit;
    lz  = '0;
    hit = 1'b0;
    for (int k = 22; k >= 0; k--) begin
      if (!hit && op.frac[k]) begin
        lz  = 5'(22 - k);
        hit = 1'b1;
      end
    end
  end

  assign sh_frac = {1'b0, op.frac} << (6'(lz) + 6'd1);
  assign frac_n  = is_sub ? sh_frac[22:0] : op.frac;
  assign eb_eff  = is_sub ? -(11'(lz)) : 11'(op.exp);

  // seed + one Newton-Raphson step: y1 = y0 * (2 - m*y0)
  logic [SEED_W-1:0] seed;
  logic [P_W-1:0]    prod;
  logic [E_W-1:0]    err;
  logic [Y_W-1:0]    y1;

  rcp_seed_rom #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_seed (
    .idx_i  (frac_n[22 -: IDX_W]),
    .seed_o (seed)
  );

  assign prod = P_W'({1'b1, frac_n}) * P_W'(seed);
  assign err  = (E_W'(1) << P_W) - E_W'(prod);
  assign y1   = Y_W'(seed) * Y_W'(err);

  logic               exact, hi;
  logic [22:0]        frac_r;
  logic signed [10:0] e_out;

  assign exact  = (frac_n == '0);
  assign hi     = y1[H];
  assign frac_r = exact ? '0 : (hi ? y1[H-1 -: 23] : y1[H-2 -: 23]);
  assign e_out  = exact ? (11'sd254 - eb_eff)
                        : (11'sd253 - eb_eff - (hi ? 11'sd0 : 11'sd1));

  logic [1:0]  dn_sh;
  logic [23:0] dn_frac;
  assign dn_sh   = 2'(11'sd1 - e_out);
  assign dn_frac = {1'b1, frac_r} >> dn_sh;

  logic unused_bits;
  assign unused_bits = ^{y1[Y_W-1:H+1], y1[H-25:0], dn_frac[23]};

  always_comb begin
    if (is_nan)                 rcp_o = {op.sign, EXP_ALL1, 1'b1, op.frac[21:0]};
    else if (is_inf)            rcp_o = {op.sign, 31'h0};
    else if (is_zero)           rcp_o = {op.sign, INF_MAG};
    else if (e_out >= 11'sd255) rcp_o = {op.sign, INF_MAG};
    else if (e_out >= 11'sd1)   rcp_o = {op.sign, e_out[7:0], frac_r};
    else if (ftz_i)             rcp_o = {op.sign, 31'h0};
    else                        rcp_o = {op.sign, 8'h00, dn_frac[22:0]};
  end

  // R8
  always_comb if (is_nan) nan_quiet_chk: assert (rcp_o[30:22] == 9'h1FF && rcp_o[21:0] == op_i[21:0] && rcp_o[31] == op_i[31]);
  // R9
  always_comb if (is_inf) inf_to_zero_chk: assert (rcp_o == {op_i[31], 31'h0});
  // R5
  always_comb if (op_i[30:0] == '0) zero_to_inf_chk: assert (rcp_o == {op_i[31], INF_MAG});
  // R6
  always_comb if (is_sub && daz_i) daz_inf_chk: assert (rcp_o == {op_i[31], INF_MAG});
endmodule

// File: rtl/masked_rcp_unit.sv
module masked_rcp_unit #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned SEED_W = 16,
  parameter int unsigned HI_W   = 96
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [HI_W-1:0] src1_hi_i,
  input  logic [31:0]     src2_lo_i,
  input  logic [31:0]     dst_lo_i,
  input  logic            mask_i,
  input  logic            mask_en_i,
  input  logic            zero_mask_i,
  input  logic            daz_i,
  input  logic            ftz_i,
  output logic            valid_o,
  output logic [HI_W+31:0] res_o
);
  logic [31:0] rcp, lo_sel;

  rcp_approx_core #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_core (
    .op_i  (src2_lo_i),
    .daz_i (daz_i),
    .ftz_i (ftz_i),
    .rcp_o (rcp)
  );

  always_comb begin
    if (!mask_en_i || mask_i) lo_sel = rcp;
    else if (zero_mask_i)     lo_sel = '0;
    else                      lo_sel = dst_lo_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= {src1_hi_i, lo_sel};
    end
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R11
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(res_o)));
  // R2
  upper_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> res_o[HI_W+31:32] == $past(src1_hi_i));
  // R4
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_en_i && !mask_i && zero_mask_i) |=> res_o[31:0] == 32'h0);
  // R4
  merge_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_en_i && !mask_i && !zero_mask_i) |=> res_o[31:0] == $past(dst_lo_i));
endmodule

// File: tb/tb_masked_rcp_unit.sv
`timescale 1ns/1ps
module tb_masked_rcp_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [95:0]  src1 = '0;
  logic [31:0]  src2 = '0, dst = '0;
  logic         mask = 1'b0, men = 1'b0, zm = 1'b0, daz = 1'b0, ftz = 1'b0;
  logic         valid_o;
  logic [127:0] res;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  masked_rcp_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .src1_hi_i(src1),
    .src2_lo_i(src2), .dst_lo_i(dst), .mask_i(mask), .mask_en_i(men),
    .zero_mask_i(zm), .daz_i(daz), .ftz_i(ftz), .valid_o(valid_o), .res_o(res)
  );

  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    32'h3F80_0000, 32'h3FC0_0000, 32'h3FFF_FFFF, 32'h3F80_0001,
    32'h4049_0FDB, 32'hC2F6_E979, 32'h7F7F_FFFF, 32'h0080_0000,
    32'h3F35_04F3, 32'h447A_0000, 32'hBE80_0000, 32'h3F81_0000
  };

  function automatic real f2r(logic [31:0] b);
    real v;
    if (b[30:23] == 8'd0) v = real'(b[22:0]) * (2.0 ** -149.0);
    else v = (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** (real'(b[30:23]) - 127.0));
    return b[31] ? -v : v;
  endfunction

  task automatic check_eq(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic check_rcp(string tag, logic [31:0] x, logic [31:0] got);
    real want, tol, diff;
    want = 1.0 / f2r(x);
    tol  = (want < 0.0 ? -want : want) * (2.0 ** -14.0) + (2.0 ** -148.0);
    diff = f2r(got) - want;
    if (diff < 0.0) diff = -diff;
    n_vec++;
    if (got[30:23] == 8'hFF || diff >= tol) begin
      n_bad++;
      $display("FAIL %s: in %08h got %08h (%e) expected %e", tag, x, got, f2r(got), want);
    end
  endtask

  // inputs set at negedge; result sampled at following negedge
  task automatic fire();
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic op(logic [31:0] x, logic d, logic f);
    src2 = x; daz = d; ftz = f; men = 1'b0;
    fire();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    check_eq("R11 reset valid", {31'h0, valid_o}, 32'h0);
    check_eq("R11 reset res", res[31:0], 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 table walk
    for (int i = 0; i < NV; i++) begin
      src1 = {3{32'hA5A5_0000 + 32'(i)}};
      op(VEC[i], 1'b0, 1'b0);
      check_rcp("R1 R3 vector", VEC[i], res[31:0]);
      check_eq("R2 upper bits", res[63:32], 32'hA5A5_0000 + 32'(i));
    end

    // R3 masking enabled, bit set
    src2 = 32'h4000_0000; men = 1'b1; mask = 1'b1; zm = 1'b1; fire();
    check_eq("R3 mask set", res[31:0], 32'h3F00_0000);
    // R4 merge
    dst = 32'h1234_5678; mask = 1'b0; zm = 1'b0; src1 = {96{1'b1}}; fire();
    check_eq("R4 merge", res[31:0], 32'h1234_5678);
    check_eq("R2 upper masked", res[127:96], 32'hFFFF_FFFF);
    // R4 zeroing
    zm = 1'b1; fire();
    check_eq("R4 zeroing", res[31:0], 32'h0);
    // R3 mask disabled ignores mask bit
    men = 1'b0; mask = 1'b0; fire();
    check_eq("R3 mask disabled", res[31:0], 32'h3F00_0000);

    // R5 zeros
    op(32'h0000_0000, 1'b0, 1'b0); check_eq("R5 +0", res[31:0], 32'h7F80_0000);
    op(32'h8000_0000, 1'b0, 1'b0); check_eq("R5 -0", res[31:0], 32'hFF80_0000);
    // R6 subnormal operands
    op(32'h0040_0000, 1'b0, 1'b0); check_eq("R6 sub computed", res[31:0], 32'h7F00_0000);
    op(32'h0040_0000, 1'b1, 1'b0); check_eq("R6 daz", res[31:0], 32'h7F80_0000);
    op(32'h8000_0001, 1'b1, 1'b0); check_eq("R6 daz neg", res[31:0], 32'hFF80_0000);
    op(32'h0060_0000, 1'b0, 1'b0); check_rcp("R6 sub approx", 32'h0060_0000, res[31:0]);
    // R10 overflow
    op(32'h0000_0001, 1'b0, 1'b0); check_eq("R10 ovf", res[31:0], 32'h7F80_0000);
    op(32'h8000_0003, 1'b0, 1'b0); check_eq("R10 ovf neg", res[31:0], 32'hFF80_0000);
    // R7 underflow
    op(32'h7F00_0000, 1'b0, 1'b0); check_eq("R7 denorm", res[31:0], 32'h0040_0000);
    op(32'h7F00_0000, 1'b0, 1'b1); check_eq("R7 ftz", res[31:0], 32'h0);
    op(32'hFF00_0000, 1'b0, 1'b1); check_eq("R7 ftz neg", res[31:0], 32'h8000_0000);
    op(32'h7EC0_0000, 1'b0, 1'b0); check_rcp("R7 denorm approx", 32'h7EC0_0000, res[31:0]);
    op(32'h7E80_0000, 1'b0, 1'b1); check_eq("R7 boundary normal", res[31:0], 32'h0080_0000);
    // R8 NaN
    op(32'h7F80_0001, 1'b0, 1'b0); check_eq("R8 snan", res[31:0], 32'h7FC0_0001);
    op(32'hFFC0_1234, 1'b0, 1'b0); check_eq("R8 qnan", res[31:0], 32'hFFC0_1234);
    // R9 infinity
    op(32'h7F80_0000, 1'b0, 1'b0); check_eq("R9 +inf", res[31:0], 32'h0);
    op(32'hFF80_0000, 1'b0, 1'b0); check_eq("R9 -inf", res[31:0], 32'h8000_0000);
    // R12 exact powers of two
    op(32'h4100_0000, 1'b0, 1'b0); check_eq("R12 exact 8", res[31:0], 32'h3E00_0000);
    op(32'hBE80_0000, 1'b0, 1'b0); check_eq("R12 exact -0.25", res[31:0], 32'hC080_0000);

    // R11 hold when idle
    check_eq("R11 valid after op", {31'h0, valid_o}, 32'h1);
    src2 = 32'h4000_0000; src1 = '0;
    @(negedge clk);
    check_eq("R11 idle valid", {31'h0, valid_o}, 32'h0);
    check_eq("R11 idle hold", res[31:0], 32'hC080_0000);
    check_eq("R11 idle hold hi", res[63:32], 32'hFFFF_FFFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule